// File: doc/BRIEF.md
# CAN Transmit Driver Guard with Dominant Timeout

This block sits between a CAN protocol controller and the bus driver stage of a transceiver. It decides on every clock whether the driver may put the bus into the dominant state. Transmit data arrives on `tx_data_i`, where 0 means dominant and 1 means recessive. A listen-only select and a thermal-fault flag can each switch the driver off. The block first synchronizes the transmit line. It then lets a dominant request through only in the active mode, and only while no timeout is in force.

A watchdog runs while the synchronized transmit line is dominant in the active mode. It bounds how long a stuck controller can hold the bus. When the limit is reached, the block drops the driver enable, forces the bus request recessive and sets a timeout flag. The flag stays set until the synchronized transmit line makes a recessive-going edge, which frees the bus for the other nodes. The timeout length is set in clock cycles. It is raised automatically so that it never falls below eleven bit times, because a legal frame may contain eleven dominant bits in a row.

The receive direction does not pass through this block, so nothing here can gate or delay it.

Top module: `can_drv_guard`

## Requirements
- R1: `bus_dom_o` is 1 only when the synchronized transmit line is 0 (dominant), `silent_i` is 0, `thermal_fault_i` is 0 and `tmo_flag_o` is 0. For every other combination it is 0, and `tx_data_i` = 1 always gives a recessive request.
- R2: While `silent_i` is 1, `drv_en_o` and `bus_dom_o` are 0 in the same cycle, whatever `tx_data_i` does.
- R3: While `thermal_fault_i` is 1, `drv_en_o` and `bus_dom_o` are 0 in the same cycle, whatever the other inputs do.
- R4: `tx_data_i` passes through SYNC_STAGES flops (default 2). A change sampled at clock edge k first shows on `bus_dom_o` after edge k+SYNC_STAGES-1.
- R5: With the active mode held and the transmit line held dominant, `bus_dom_o` is 1 for exactly EFF consecutive cycles. After that, `tmo_flag_o` is 1 and `drv_en_o` is 0.
- R6: Once set, `tmo_flag_o` holds, including through the listen-only and thermal modes. It clears only one clock after the synchronized transmit line rises, and that rise clears it in any mode.
- R7: EFF is the larger of TMO_CYCLES and 11*BIT_CYCLES.
- R8: Dominant cycles are counted only in the active mode. Any cycle in the listen-only or thermal mode restarts the count at zero.
- R9: After reset the synchronizer holds recessive, `bus_dom_o` is 0 and `tmo_flag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_data_i | input | 1 | Transmit data from the controller, 0 = dominant |
| silent_i | input | 1 | Listen-only select, 1 = driver off |
| thermal_fault_i | input | 1 | Over-temperature indication, 1 = driver off |
| drv_en_o | output | 1 | Driver stage enable |
| bus_dom_o | output | 1 | Effective dominant request to the bus stage |
| tmo_flag_o | output | 1 | Dominant timeout in force |

## Verification
The mode inputs act combinationally, so `drv_en_o` and `bus_dom_o` must follow `silent_i` and `thermal_fault_i` in the same cycle. A transmit-line change reaches `bus_dom_o` after two edges, and a recessive-going edge clears `tmo_flag_o` after three edges. The timeout appears on the edge that ends the EFF-th dominant cycle. The bench drives inputs just after the falling clock edge and compares every output against its behavioural model at each falling edge. Directed checks count ticks from each stimulus to those exact edges, for example two ticks after a rise with the flag still set and three ticks with it cleared.

// File: rtl/can_guard_pkg.sv
package can_guard_pkg;

    // Longest legal run of dominant bits in a frame (stuff error plus error flag)
    localparam int unsigned MIN_DOM_BITS = 11;

    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'd0,
        MODE_LISTEN = 2'd1,
        MODE_HOT    = 2'd2
    } drv_mode_e;

    typedef struct packed {
        logic level;  // synchronized line, 1 = recessive
        logic rose;   // recessive-going edge this cycle
        logic fell;   // dominant-going edge this cycle
    } txd_view_t;

    function automatic int unsigned eff_timeout(int unsigned tmo, int unsigned bit_cyc);
        int unsigned floor_c;
        floor_c = MIN_DOM_BITS * bit_cyc;
        return (tmo > floor_c) ? tmo : floor_c;
    endfunction

    // Thermal fault has priority over the listen-only select
    function automatic drv_mode_e pick_mode(logic silent, logic hot);
        if (hot)
            return MODE_HOT;
        else if (silent)
            return MODE_LISTEN;
        else
            return MODE_ACTIVE;
    endfunction

endpackage

// File: rtl/can_txd_sync.sv
module can_txd_sync
    import can_guard_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      raw_i,
    output txd_view_t view_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= raw_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], raw_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= chain_q[STAGES-1];
    end

    always_comb begin
        view_o.level = chain_q[STAGES-1];
        view_o.rose  = chain_q[STAGES-1] & ~last_q;
        view_o.fell  = ~chain_q[STAGES-1] & last_q;
    end

endmodule

// File: rtl/can_dom_timer.sv
module can_dom_timer
    import can_guard_pkg::*;
#(
    parameter int unsigned LIMIT = 1000
) (
    input  logic      clk,
    input  logic      rst,
    input  txd_view_t view_i,
    input  drv_mode_e mode_i,
    output logic      expired_o
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          expired_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            expired_q <= 1'b0;
        end else if (view_i.rose) begin
            cnt_q     <= '0;
            expired_q <= 1'b0;
        end else if (mode_i != MODE_ACTIVE || view_i.level) begin
            cnt_q <= '0;
        end else if (view_i.fell) begin
            cnt_q     <= ONE;
            expired_q <= (LIMIT == 1);
        end else if (!expired_q) begin
            if (cnt_q == LIM - ONE)
                expired_q <= 1'b1;
            if (cnt_q != LIM)
                cnt_q <= cnt_q + ONE;
        end
    end

    assign expired_o = expired_q;

endmodule

// File: rtl/can_drv_gate.sv
module can_drv_gate
    import can_guard_pkg::*;
(
    input  drv_mode_e mode_i,
    input  logic      level_i,
    input  logic      expired_i,
    output logic      drv_en_o,
    output logic      bus_dom_o
);

    always_comb begin
        drv_en_o  = (mode_i == MODE_ACTIVE) && !expired_i;
        bus_dom_o = drv_en_o && !level_i;
    end

endmodule

// File: rtl/can_drv_guard.sv
module can_drv_guard
    import can_guard_pkg::*;
#(
    parameter int unsigned TMO_CYCLES  = 1000,
    parameter int unsigned BIT_CYCLES  = 50,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_data_i,
    input  logic silent_i,
    input  logic thermal_fault_i,
    output logic drv_en_o,
    output logic bus_dom_o,
    output logic tmo_flag_o
);

    localparam int unsigned EFF = eff_timeout(TMO_CYCLES, BIT_CYCLES);

    txd_view_t view;
    drv_mode_e mode;
    logic      expired;

    assign mode = pick_mode(silent_i, thermal_fault_i);

    can_txd_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (tx_data_i),
        .view_o (view)
    );

    can_dom_timer #(.LIMIT(EFF)) timer_i (
        .clk       (clk),
        .rst       (rst),
        .view_i    (view),
        .mode_i    (mode),
        .expired_o (expired)
    );

    can_drv_gate gate_i (
        .mode_i    (mode),
        .level_i   (view.level),
        .expired_i (expired),
        .drv_en_o  (drv_en_o),
        .bus_dom_o (bus_dom_o)
    );

    assign tmo_flag_o = expired;

endmodule

// File: rtl/can_drv_guard_chk.sv
module can_drv_guard_chk
    import can_guard_pkg::*;
#(
    parameter int unsigned TMO_CYCLES  = 1000,
    parameter int unsigned BIT_CYCLES  = 50,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst,
    input logic tx_data_i,
    input logic silent_i,
    input logic thermal_fault_i,
    input logic drv_en_o,
    input logic bus_dom_o,
    input logic tmo_flag_o
);

    localparam int unsigned EFF = eff_timeout(TMO_CYCLES, BIT_CYCLES);

    int unsigned dom_run;

    always_ff @(posedge clk) begin
        if (rst)            dom_run <= 0;
        else if (bus_dom_o) dom_run <= dom_run + 1;
        else                dom_run <= 0;
    end

    assert_dom_gated_R1: assert property (@(posedge clk) disable iff (rst)
        bus_dom_o |-> (drv_en_o && !tmo_flag_o && !$past(tx_data_i, SYNC_STAGES)));

    assert_listen_off_R2: assert property (@(posedge clk) disable iff (rst)
        silent_i |-> (!drv_en_o && !bus_dom_o));

    assert_hot_off_R3: assert property (@(posedge clk) disable iff (rst)
        thermal_fault_i |-> (!drv_en_o && !bus_dom_o));

    assert_run_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        bus_dom_o |-> (dom_run < EFF));

    assert_tmo_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        tmo_flag_o |-> !drv_en_o);

    assert_clear_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(tmo_flag_o) |-> ($past(tx_data_i, SYNC_STAGES + 1) && !$past(tx_data_i, SYNC_STAGES + 2)));

    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bus_dom_o && !tmo_flag_o));

endmodule

bind can_drv_guard can_drv_guard_chk #(
    .TMO_CYCLES  (TMO_CYCLES),
    .BIT_CYCLES  (BIT_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
) chk_i (
    .clk             (clk),
    .rst             (rst),
    .tx_data_i       (tx_data_i),
    .silent_i        (silent_i),
    .thermal_fault_i (thermal_fault_i),
    .drv_en_o        (drv_en_o),
    .bus_dom_o       (bus_dom_o),
    .tmo_flag_o      (tmo_flag_o)
);

// File: tb/can_drv_guard_tb_top.sv
`timescale 1ns/1ps
module can_drv_guard_tb_top;

    localparam int EFF_A = 20;   // TMO 20, BIT 1 -> 20
    localparam int EFF_B = 22;   // TMO 5, BIT 2 -> 22

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx = 1'b1, silent = 1'b0, hot = 1'b0;
    logic tx2 = 1'b1;
    logic drv_en, bus_dom, tmo_flag;
    logic drv_en2, bus_dom2, tmo_flag2;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    can_drv_guard #(.TMO_CYCLES(20), .BIT_CYCLES(1), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .tx_data_i(tx), .silent_i(silent),
        .thermal_fault_i(hot), .drv_en_o(drv_en), .bus_dom_o(bus_dom),
        .tmo_flag_o(tmo_flag)
    );

    can_drv_guard #(.TMO_CYCLES(5), .BIT_CYCLES(2), .SYNC_STAGES(2)) dut_clamp_i (
        .clk(clk), .rst(rst), .tx_data_i(tx2), .silent_i(1'b0),
        .thermal_fault_i(1'b0), .drv_en_o(drv_en2), .bus_dom_o(bus_dom2),
        .tmo_flag_o(tmo_flag2)
    );

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic hist[$] = '{1'b1, 1'b1, 1'b1};  // [0] newest sample
    int   m_run = 0;
    bit   m_tmo = 0;

    always @(posedge clk) begin
        if (rst) begin
            hist  = '{1'b1, 1'b1, 1'b1};
            m_run = 0;
            m_tmo = 0;
        end else begin
            automatic bit lvl = hist[1];
            automatic bit prv = hist[2];
            automatic bit normal = !silent && !hot;
            if (lvl && !prv) begin
                m_run = 0;
                m_tmo = 0;
            end else if (!normal || lvl) begin
                m_run = 0;
            end else if (!m_tmo) begin
                m_run++;
                if (m_run >= EFF_A) m_tmo = 1;
            end
            hist.push_front(tx);
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            automatic bit normal = !silent && !hot;
            automatic bit e_en  = normal && !m_tmo;
            automatic bit e_dom = e_en && !hist[1];
            chk("R1 model bus_dom_o", bus_dom, e_dom);
            chk("R2/R3 model drv_en_o", drv_en, e_en);
            chk("R6 model tmo_flag_o", tmo_flag, m_tmo);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int cnt;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R9: idle after reset
        chk("R9 bus_dom_o after reset", bus_dom, 0);
        chk("R9 tmo_flag_o after reset", tmo_flag, 0);
        chk("R9 drv_en_o after reset", drv_en, 1);

        // R4: two-edge latency
        tx = 1'b0;
        tick(1);
        chk("R4 bus_dom_o after one edge", bus_dom, 0);
        tick(1);
        chk("R4 bus_dom_o after two edges", bus_dom, 1);
        tx = 1'b1;
        tick(3);
        chk("R1 recessive data gives recessive", bus_dom, 0);

        // R1 toggling pattern, no timeout
        for (int i = 0; i < 12; i++) begin
            tx = i[0];
            tick(3);
        end
        tx = 1'b1;
        tick(4);
        chk("R1 toggling leaves flag clear", tmo_flag, 0);

        // R5: stuck dominant
        cnt = 0;
        tx = 1'b0;
        for (int i = 0; i < 40; i++) begin
            tick(1);
            if (bus_dom) cnt++;
        end
        chk("R5 dominant cycle count", cnt, EFF_A);
        chk("R5 flag set", tmo_flag, 1);
        chk("R5 driver disabled", drv_en, 0);

        // R6: listen and thermal do not clear
        silent = 1'b1; tick(2); silent = 1'b0; tick(2);
        chk("R6 flag survives listen mode", tmo_flag, 1);
        hot = 1'b1; tick(2); hot = 1'b0; tick(2);
        chk("R6 flag survives thermal mode", tmo_flag, 1);
        tx = 1'b1;
        tick(2);
        chk("R6 flag held two edges after rise", tmo_flag, 1);
        tick(1);
        chk("R6 flag clear three edges after rise", tmo_flag, 0);
        chk("R6 driver re-enabled", drv_en, 1);

        // R6: rise during listen mode clears
        tx = 1'b0; tick(30);
        chk("R6 flag set again", tmo_flag, 1);
        silent = 1'b1; tx = 1'b1; tick(4);
        chk("R6 rise in listen mode clears", tmo_flag, 0);
        silent = 1'b0; tick(2);

        // R2: listen mode blocks dominant
        tx = 1'b0; silent = 1'b1; tick(3);
        chk("R2 bus_dom_o in listen mode", bus_dom, 0);
        chk("R2 drv_en_o in listen mode", drv_en, 0);
        silent = 1'b0; tick(1);
        chk("R2 dominant resumes after listen", bus_dom, 1);

        // R3: thermal blocks dominant
        hot = 1'b1; tick(1);
        chk("R3 bus_dom_o under thermal fault", bus_dom, 0);
        chk("R3 drv_en_o under thermal fault", drv_en, 0);
        hot = 1'b0; tx = 1'b1; tick(4);

        // R8: listen cycle restarts count
        tx = 1'b0; tick(16);
        silent = 1'b1; tick(1); silent = 1'b0;
        tick(15);
        chk("R8 restart avoids timeout", tmo_flag, 0);
        chk("R8 still dominant", bus_dom, 1);
        tick(10);
        chk("R8 timeout after fresh full run", tmo_flag, 1);
        tx = 1'b1; tick(4);

        // R7: clamp to eleven bit times
        cnt = 0;
        tx2 = 1'b0;
        for (int i = 0; i < 40; i++) begin
            tick(1);
            if (bus_dom2) cnt++;
        end
        chk("R7 clamped dominant count", cnt, EFF_B);
        chk("R7 clamped flag set", tmo_flag2, 1);
        tx2 = 1'b1; tick(4);
        chk("R7 clamped flag clears", tmo_flag2, 0);

        finish_up();
    end

endmodule